// File: doc/BRIEF.md
# Offline Function Register Access Gate

This block sits between a register-access bus and the register file of one controller function. The function may be the physical primary function or a virtual function. While a virtual function is marked offline, the gate stops register reads and writes from reaching the register file. Reads come back as zero and writes are dropped. One register is exempt: the controller status register, at byte offset 0x1C, stays reachable. The gate also refuses a controller-enable request on an offline virtual function.

On every function reset, the gate tells the register file what value to load into the status register. An offline virtual function gets the controller-fatal flag; any other case gets zero. At a function-level reset it also latches how many I/O queue pairs and interrupt vectors the function will expose. A virtual function derives these from its own assigned resources. The primary derives them from its private resources plus its pending flexible allocations, which become active at that moment.

A separate configuration-write monitor watches the SR-IOV control byte. When a write covers that byte and leaves VF enable cleared, it raises a request, in the same cycle, to force the first NumVFs secondary functions offline. The write itself is handed on one cycle later, so the request always comes before the write is applied.

Top module: `fn_access_gate`

## Requirements
- R1: A read is blocked when `isVf`=1, `fnOnline`=0 and the access word address (`busAddr[11:2]`) differs from word 7 (byte 0x1C). A blocked read is not forwarded, and `busRdata` is zero in the cycle after the request, which is when forwarded reads return `regRdata`.
- R2: A write under the same blocking condition as R1 is not forwarded: `regValid` stays 0 in the request cycle.
- R3: An access whose word address equals 0x1C>>2 is always forwarded, whatever the values of address bits [1:0]. Every access is forwarded when `isVf`=0 or `fnOnline`=1, with `regAddr`, `regWrite` and `regWdata` equal to the bus values in the same cycle and `busRdata` equal to `regRdata` one cycle later.
- R4: Each blocked access, read or write, produces `ignoredPulse`=1 for exactly the one cycle after the request. Any other access leaves it at 0.
- R5: In the cycle after an `enableReq` pulse, exactly one of `startFail` and `startGo` is 1. `startFail` is the one when the function is an offline virtual function; otherwise it is `startGo`.
- R6: A `fnReset` pulse, of either kind, gives `stsLoad`=1 in the next cycle. `stsLoadVal` is then 0x2 (controller-fatal, bit 1) for an offline virtual function and 0 otherwise.
- R7: At a function-level reset (`fnResetFull`=1) of a virtual function, `ioQueuePairs` becomes `vfQueues`-1 (0 when `vfQueues`=0) and `intVectors` becomes `vfIntrs` (1 when `vfIntrs`=0), both visible in the next cycle.
- R8: At a function-level reset of the primary, `activeFlexQ`/`activeFlexI` take the values of `pendFlexQ`/`pendFlexI`. `ioQueuePairs` becomes `priPrivQ`+`pendFlexQ`-1 (0 if that sum is 0) and `intVectors` becomes `priPrivI`+`pendFlexI`.
- R9: A controller reset (`fnResetFull`=0) leaves `ioQueuePairs`, `intVectors`, `activeFlexQ` and `activeFlexI` unchanged.
- R10: When a configuration write hits the word holding SR-IOV control byte 0x168 with byte-enable bit 0 set and data bit 0 (VF enable) equal to 0, `offlineReq` is 1 in the same cycle with `offlineCount`=`numVfs`. Otherwise `offlineReq`=0 and `offlineCount`=0.
- R11: Every configuration write is presented on `cfgApply` with its address, byte enables and data one cycle after it arrives, so it always follows any `offlineReq` it caused.
- R12: After reset, all pulse outputs are 0, and the capacity and active-allocation outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isVf | input | 1 | Function is a virtual function |
| fnOnline | input | 1 | Function online state |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | Access is a write |
| busAddr | input | 12 | Access byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after request |
| regValid | output | 1 | Forwarded access to register file |
| regWrite | output | 1 | Forwarded write flag |
| regAddr | output | 12 | Forwarded address |
| regWdata | output | 32 | Forwarded write data |
| regRdata | input | 32 | Register file read data, one cycle after request |
| ignoredPulse | output | 1 | Blocked access indication |
| enableReq | input | 1 | Controller enable request pulse |
| startGo | output | 1 | Controller may start |
| startFail | output | 1 | Controller enable refused |
| fnReset | input | 1 | Function reset pulse |
| fnResetFull | input | 1 | 1: function-level reset, 0: controller reset |
| stsLoad | output | 1 | Load status register strobe |
| stsLoadVal | output | 32 | Value to load into status register |
| vfQueues | input | 8 | Queues assigned to this virtual function |
| vfIntrs | input | 8 | Interrupts assigned to this virtual function |
| priPrivQ | input | 8 | Primary private queues |
| priPrivI | input | 8 | Primary private interrupts |
| pendFlexQ | input | 8 | Primary pending flexible queues |
| pendFlexI | input | 8 | Primary pending flexible interrupts |
| activeFlexQ | output | 8 | Primary active flexible queues |
| activeFlexI | output | 8 | Primary active flexible interrupts |
| ioQueuePairs | output | 9 | Exposed I/O queue pairs |
| intVectors | output | 9 | Exposed interrupt vectors |
| cfgValid | input | 1 | Configuration write |
| cfgAddr | input | 12 | Configuration byte address |
| cfgBe | input | 4 | Configuration byte enables |
| cfgData | input | 32 | Configuration write data |
| numVfs | input | 16 | Current number of enabled secondaries |
| offlineReq | output | 1 | Force secondaries offline |
| offlineCount | output | 16 | Number of secondaries to force offline |
| cfgApply | output | 1 | Configuration write to apply |
| cfgApplyAddr | output | 12 | Applied write address |
| cfgApplyBe | output | 4 | Applied write byte enables |
| cfgApplyData | output | 32 | Applied write data |

## Verification
The bench sweeps every mix of function type, online state, read or write, and a range of word addresses. The range includes the status word reached through unaligned byte addresses and a high address that aliases the status word's low bits. A gate that compared full byte addresses would block the status register on an unaligned access, and one that compared too few address bits would let the aliased address through. The capacity sweeps include zero queues and zero interrupts: an unclamped subtraction would wrap to a large queue-pair count, and a missing floor would expose zero vectors. Controller resets are mixed with function-level resets, so a design that latched capacity or activated pending allocations on every reset is caught. Configuration writes that miss the byte lane, set VF enable, or hit the neighbouring word must raise no offline request.

// File: rtl/fn_gate_pkg.sv
package fn_gate_pkg;

  // Strobes produced by the control decision and consumed by the datapath.
  typedef struct packed {
    logic passAcc;    // access forwarded to register file
    logic blockAcc;   // access blocked by offline gate
    logic blockRd;    // blocked access is a read
    logic startGo;    // enable request accepted
    logic startFail;  // enable request refused
    logic stsLoad;    // reset requests status reload
    logic stsFatal;   // reload value carries fatal flag
    logic capLoad;    // function-level reset latches capacity
  } gateStrobes_t;

endpackage

// File: rtl/fn_gate_ctrl.sv
module fn_gate_ctrl
  import fn_gate_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_W     = 12,
  parameter int NVF_W     = 16,
  parameter int STS_OFS   = 'h1C,
  parameter int CTRL_OFS  = 'h168,
  parameter int VFE_BIT   = 0
) (
  input  logic             isVf,
  input  logic             fnOnline,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic             enableReq,
  input  logic             fnReset,
  input  logic             fnResetFull,
  input  logic             cfgValid,
  input  logic [CFG_W-1:0] cfgAddr,
  input  logic [3:0]       cfgBe,
  input  logic [31:0]      cfgData,
  input  logic [NVF_W-1:0] numVfs,
  output gateStrobes_t     strobes,
  output logic             offlineReq,
  output logic [NVF_W-1:0] offlineCount
);

  localparam logic [ADDR_W-1:0] STS_ADDR  = ADDR_W'(STS_OFS);
  localparam logic [CFG_W-1:0]  CTRL_ADDR = CFG_W'(CTRL_OFS);
  localparam int                CTRL_LANE = CTRL_OFS % 4;
  localparam int                VFE_POS   = 8 * CTRL_LANE + VFE_BIT;

  logic fnOffline;
  logic stsHit;
  logic gateOn;
  logic ctrlWordHit;
  logic ctrlCovered;

  // Offline applies only to virtual functions; status word is exempt.
  assign fnOffline = isVf & ~fnOnline;
  assign stsHit    = busAddr[ADDR_W-1:2] == STS_ADDR[ADDR_W-1:2];
  assign gateOn    = fnOffline & ~stsHit;

  always_comb begin
    strobes           = '0;
    strobes.passAcc   = busValid & ~gateOn;
    strobes.blockAcc  = busValid & gateOn;
    strobes.blockRd   = busValid & gateOn & ~busWrite;
    strobes.startGo   = enableReq & ~fnOffline;
    strobes.startFail = enableReq & fnOffline;
    strobes.stsLoad   = fnReset;
    strobes.stsFatal  = fnReset & fnOffline;
    strobes.capLoad   = fnReset & fnResetFull;
  end

  // Configuration monitor: clearing VF enable takes secondaries offline
  // in the same cycle, ahead of the registered write hand-off.
  assign ctrlWordHit  = cfgAddr[CFG_W-1:2] == CTRL_ADDR[CFG_W-1:2];
  assign ctrlCovered  = ctrlWordHit & cfgBe[CTRL_LANE];
  assign offlineReq   = cfgValid & ctrlCovered & ~cfgData[VFE_POS];
  assign offlineCount = offlineReq ? numVfs : '0;

endmodule

// File: rtl/fn_gate_dp.sv
module fn_gate_dp
  import fn_gate_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_W     = 12,
  parameter int CNT_W     = 8,
  parameter int FATAL_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobes_t      strobes,
  input  logic              isVf,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              regValid,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata,
  output logic              ignoredPulse,
  output logic              startGo,
  output logic              startFail,
  output logic              stsLoad,
  output logic [31:0]       stsLoadVal,
  input  logic [CNT_W-1:0]  vfQueues,
  input  logic [CNT_W-1:0]  vfIntrs,
  input  logic [CNT_W-1:0]  priPrivQ,
  input  logic [CNT_W-1:0]  priPrivI,
  input  logic [CNT_W-1:0]  pendFlexQ,
  input  logic [CNT_W-1:0]  pendFlexI,
  output logic [CNT_W-1:0]  activeFlexQ,
  output logic [CNT_W-1:0]  activeFlexI,
  output logic [CNT_W:0]    ioQueuePairs,
  output logic [CNT_W:0]    intVectors,
  input  logic              cfgValid,
  input  logic [CFG_W-1:0]  cfgAddr,
  input  logic [3:0]        cfgBe,
  input  logic [31:0]       cfgData,
  output logic              cfgApply,
  output logic [CFG_W-1:0]  cfgApplyAddr,
  output logic [3:0]        cfgApplyBe,
  output logic [31:0]       cfgApplyData
);

  localparam int CAP_W = CNT_W + 1;
  localparam logic [31:0] FATAL_VAL = 32'(1) << FATAL_BIT;

  logic             blockRdQ;
  logic [CAP_W-1:0] vfQp, vfIv, priSumQ, priQp, priIv;

  // Forward path: fields pass straight through, valid is gated.
  assign regValid = strobes.passAcc;
  assign regWrite = busWrite;
  assign regAddr  = busAddr;
  assign regWdata = busWdata;
  assign busRdata = blockRdQ ? '0 : regRdata;

  // Capacity arithmetic: one queue is reserved for administration.
  assign vfQp    = (vfQueues == '0) ? '0 : CAP_W'(vfQueues) - CAP_W'(1);
  assign vfIv    = (vfIntrs == '0) ? CAP_W'(1) : CAP_W'(vfIntrs);
  assign priSumQ = CAP_W'(priPrivQ) + CAP_W'(pendFlexQ);
  assign priQp   = (priSumQ == '0) ? '0 : priSumQ - CAP_W'(1);
  assign priIv   = CAP_W'(priPrivI) + CAP_W'(pendFlexI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockRdQ     <= 1'b0;
      ignoredPulse <= 1'b0;
      startGo      <= 1'b0;
      startFail    <= 1'b0;
      stsLoad      <= 1'b0;
      stsLoadVal   <= '0;
      cfgApply     <= 1'b0;
      cfgApplyAddr <= '0;
      cfgApplyBe   <= '0;
      cfgApplyData <= '0;
    end else begin
      blockRdQ     <= strobes.blockRd;
      ignoredPulse <= strobes.blockAcc;
      startGo      <= strobes.startGo;
      startFail    <= strobes.startFail;
      stsLoad      <= strobes.stsLoad;
      stsLoadVal   <= strobes.stsFatal ? FATAL_VAL : '0;
      cfgApply     <= cfgValid;
      cfgApplyAddr <= cfgAddr;
      cfgApplyBe   <= cfgBe;
      cfgApplyData <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeFlexQ  <= '0;
      activeFlexI  <= '0;
      ioQueuePairs <= '0;
      intVectors   <= '0;
    end else if (strobes.capLoad) begin
      if (isVf) begin
        ioQueuePairs <= vfQp;
        intVectors   <= vfIv;
      end else begin
        activeFlexQ  <= pendFlexQ;
        activeFlexI  <= pendFlexI;
        ioQueuePairs <= priQp;
        intVectors   <= priIv;
      end
    end
  end

endmodule

// File: rtl/fn_access_gate.sv
module fn_access_gate
  import fn_gate_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int CFG_W     = 12,
  parameter int CNT_W     = 8,
  parameter int NVF_W     = 16,
  parameter int STS_OFS   = 'h1C,
  parameter int FATAL_BIT = 1,
  parameter int CTRL_OFS  = 'h168,
  parameter int VFE_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isVf,
  input  logic              fnOnline,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              regValid,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [31:0]       regWdata,
  input  logic [31:0]       regRdata,
  output logic              ignoredPulse,
  input  logic              enableReq,
  output logic              startGo,
  output logic              startFail,
  input  logic              fnReset,
  input  logic              fnResetFull,
  output logic              stsLoad,
  output logic [31:0]       stsLoadVal,
  input  logic [CNT_W-1:0]  vfQueues,
  input  logic [CNT_W-1:0]  vfIntrs,
  input  logic [CNT_W-1:0]  priPrivQ,
  input  logic [CNT_W-1:0]  priPrivI,
  input  logic [CNT_W-1:0]  pendFlexQ,
  input  logic [CNT_W-1:0]  pendFlexI,
  output logic [CNT_W-1:0]  activeFlexQ,
  output logic [CNT_W-1:0]  activeFlexI,
  output logic [CNT_W:0]    ioQueuePairs,
  output logic [CNT_W:0]    intVectors,
  input  logic              cfgValid,
  input  logic [CFG_W-1:0]  cfgAddr,
  input  logic [3:0]        cfgBe,
  input  logic [31:0]       cfgData,
  input  logic [NVF_W-1:0]  numVfs,
  output logic              offlineReq,
  output logic [NVF_W-1:0]  offlineCount,
  output logic              cfgApply,
  output logic [CFG_W-1:0]  cfgApplyAddr,
  output logic [3:0]        cfgApplyBe,
  output logic [31:0]       cfgApplyData
);

  gateStrobes_t strobes;

  fn_gate_ctrl #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .NVF_W(NVF_W),
    .STS_OFS(STS_OFS), .CTRL_OFS(CTRL_OFS), .VFE_BIT(VFE_BIT)
  ) u_ctrl (
    .isVf(isVf), .fnOnline(fnOnline),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .enableReq(enableReq), .fnReset(fnReset), .fnResetFull(fnResetFull),
    .cfgValid(cfgValid), .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgData(cfgData),
    .numVfs(numVfs), .strobes(strobes),
    .offlineReq(offlineReq), .offlineCount(offlineCount)
  );

  fn_gate_dp #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .CNT_W(CNT_W), .FATAL_BIT(FATAL_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .isVf(isVf),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .ignoredPulse(ignoredPulse), .startGo(startGo), .startFail(startFail),
    .stsLoad(stsLoad), .stsLoadVal(stsLoadVal),
    .vfQueues(vfQueues), .vfIntrs(vfIntrs),
    .priPrivQ(priPrivQ), .priPrivI(priPrivI),
    .pendFlexQ(pendFlexQ), .pendFlexI(pendFlexI),
    .activeFlexQ(activeFlexQ), .activeFlexI(activeFlexI),
    .ioQueuePairs(ioQueuePairs), .intVectors(intVectors),
    .cfgValid(cfgValid), .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgData(cfgData),
    .cfgApply(cfgApply), .cfgApplyAddr(cfgApplyAddr),
    .cfgApplyBe(cfgApplyBe), .cfgApplyData(cfgApplyData)
  );

endmodule

// File: rtl/fn_access_gate_chk.sv
module fn_access_gate_chk #(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 8,
  parameter int STS_OFS = 'h1C
) (
  input logic              clk,
  input logic              rstN,
  input logic              isVf,
  input logic              fnOnline,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              regValid,
  input logic              ignoredPulse,
  input logic              enableReq,
  input logic              startGo,
  input logic              startFail,
  input logic              fnReset,
  input logic              fnResetFull,
  input logic              stsLoad,
  input logic [31:0]       stsLoadVal,
  input logic [CNT_W:0]    ioQueuePairs,
  input logic              offlineReq,
  input logic              cfgApply
);

  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(STS_OFS);

  logic offAcc;
  assign offAcc = isVf && !fnOnline && (busAddr[ADDR_W-1:2] != STS_ADDR[ADDR_W-1:2]);

  p_read_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && offAcc) |=> (busRdata == 32'h0));

  p_write_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && offAcc) |-> !regValid);

  p_status_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && (busAddr[ADDR_W-1:2] == STS_ADDR[ADDR_W-1:2])) |-> regValid);

  p_pulse_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    ignoredPulse |-> $past(busValid && offAcc));

  p_no_start_offline_r5: assert property (@(posedge clk) disable iff (!rstN)
    startGo |-> $past(enableReq && !(isVf && !fnOnline)));

  p_one_result_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({startGo, startFail}) <= 1);

  p_fatal_offline_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stsLoad && stsLoadVal != 32'h0) |-> $past(isVf && !fnOnline));

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(fnReset && fnResetFull) |-> $stable(ioQueuePairs));

  p_apply_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    offlineReq |=> cfgApply);

endmodule

bind fn_access_gate fn_access_gate_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STS_OFS(STS_OFS)
) u_chk (.*);

// File: tb/fn_access_gate_test.sv
module fn_access_gate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isVf = 1'b0, fnOnline = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic        regValid, regWrite;
  logic [11:0] regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata = 32'h1234_5678;
  logic        ignoredPulse;
  logic        enableReq = 1'b0, startGo, startFail;
  logic        fnReset = 1'b0, fnResetFull = 1'b0, stsLoad;
  logic [31:0] stsLoadVal;
  logic [7:0]  vfQueues = '0, vfIntrs = '0, priPrivQ = '0, priPrivI = '0;
  logic [7:0]  pendFlexQ = '0, pendFlexI = '0, activeFlexQ, activeFlexI;
  logic [8:0]  ioQueuePairs, intVectors;
  logic        cfgValid = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [3:0]  cfgBe = '0;
  logic [31:0] cfgData = '0;
  logic [15:0] numVfs = '0;
  logic        offlineReq;
  logic [15:0] offlineCount;
  logic        cfgApply;
  logic [11:0] cfgApplyAddr;
  logic [3:0]  cfgApplyBe;
  logic [31:0] cfgApplyData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fn_access_gate uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_reset(input logic full);
    @(negedge clk);
    fnReset = 1'b1; fnResetFull = full;
    @(negedge clk);
    fnReset = 1'b0; fnResetFull = 1'b0;
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [3:0] be,
                           input logic [31:0] d, input logic [15:0] nv,
                           input logic expOff);
    @(negedge clk);
    cfgValid = 1'b1; cfgAddr = a; cfgBe = be; cfgData = d; numVfs = nv;
    #1;
    chk("R10 offlineReq", 32'(offlineReq), 32'(expOff));
    chk("R10 offlineCount", 32'(offlineCount), expOff ? 32'(nv) : 32'h0);
    @(negedge clk);
    cfgValid = 1'b0;
    chk("R11 cfgApply", 32'(cfgApply), 32'h1);
    chk("R11 cfgApplyAddr", 32'(cfgApplyAddr), 32'(a));
    chk("R11 cfgApplyBe", 32'(cfgApplyBe), 32'(be));
    chk("R11 cfgApplyData", cfgApplyData, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic blk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ignoredPulse", 32'(ignoredPulse), 32'h0);
    chk("R12 startGo", 32'(startGo), 32'h0);
    chk("R12 startFail", 32'(startFail), 32'h0);
    chk("R12 stsLoad", 32'(stsLoad), 32'h0);
    chk("R12 ioQueuePairs", 32'(ioQueuePairs), 32'h0);
    chk("R12 intVectors", 32'(intVectors), 32'h0);
    chk("R12 activeFlexQ", 32'(activeFlexQ), 32'h0);
    chk("R12 cfgApply", 32'(cfgApply), 32'h0);

    // Access gating sweep: R1 R2 R3 R4
    for (int vf = 0; vf < 2; vf++)
      for (int on = 0; on < 2; on++)
        for (int w = 0; w < 18; w++)
          for (int wr = 0; wr < 2; wr++) begin
            if (w < 16) a = 12'(w * 4 + (w % 4));
            else if (w == 16) a = 12'h41C;
            else a = 12'h01F;
            blk = (vf == 1) && (on == 0) && (a[11:2] != 10'h7);
            @(negedge clk);
            isVf = vf[0]; fnOnline = on[0];
            busValid = 1'b1; busWrite = wr[0]; busAddr = a;
            busWdata = 32'hD00D_0000 | 32'(a);
            #1;
            chk(wr ? "R2 regValid" : "R3 regValid", 32'(regValid), 32'(!blk));
            if (!blk) begin
              chk("R3 regAddr", 32'(regAddr), 32'(a));
              chk("R3 regWrite", 32'(regWrite), 32'(wr));
              chk("R3 regWdata", regWdata, 32'hD00D_0000 | 32'(a));
            end
            @(negedge clk);
            chk("R4 ignoredPulse", 32'(ignoredPulse), 32'(blk));
            if (wr == 0)
              chk("R1 busRdata", busRdata, blk ? 32'h0 : 32'h1234_5678);
            busValid = 1'b0;
          end
    @(negedge clk);
    chk("R4 pulse clears", 32'(ignoredPulse), 32'h0);

    // Enable requests: R5
    for (int vf = 0; vf < 2; vf++)
      for (int on = 0; on < 2; on++) begin
        @(negedge clk);
        isVf = vf[0]; fnOnline = on[0]; enableReq = 1'b1;
        @(negedge clk);
        enableReq = 1'b0;
        chk("R5 startGo", 32'(startGo), 32'(!(vf == 1 && on == 0)));
        chk("R5 startFail", 32'(startFail), 32'(vf == 1 && on == 0));
        @(negedge clk);
        chk("R5 single cycle", 32'(startGo | startFail), 32'h0);
      end

    // Status reload on both reset kinds: R6
    for (int vf = 0; vf < 2; vf++)
      for (int on = 0; on < 2; on++)
        for (int k = 0; k < 2; k++) begin
          isVf = vf[0]; fnOnline = on[0];
          pulse_reset(k[0]);
          chk("R6 stsLoad", 32'(stsLoad), 32'h1);
          chk("R6 stsLoadVal", stsLoadVal, (vf == 1 && on == 0) ? 32'h2 : 32'h0);
        end

    // Virtual function capacity: R7
    isVf = 1'b1; fnOnline = 1'b1;
    for (int q = 0; q < 5; q++)
      for (int i = 0; i < 4; i++) begin
        vfQueues = 8'(q); vfIntrs = 8'(i);
        pulse_reset(1'b1);
        chk("R7 ioQueuePairs", 32'(ioQueuePairs), (q == 0) ? 32'h0 : 32'(q - 1));
        chk("R7 intVectors", 32'(intVectors), (i == 0) ? 32'h1 : 32'(i));
      end
    vfQueues = 8'd255; vfIntrs = 8'd255;
    pulse_reset(1'b1);
    chk("R7 max queues", 32'(ioQueuePairs), 32'd254);
    chk("R7 max vectors", 32'(intVectors), 32'd255);

    // Primary capacity and activation: R8
    isVf = 1'b0;
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 4; f++) begin
        priPrivQ = 8'(p); pendFlexQ = 8'(f);
        priPrivI = 8'(f); pendFlexI = 8'(p);
        pulse_reset(1'b1);
        chk("R8 ioQueuePairs", 32'(ioQueuePairs), (p + f == 0) ? 32'h0 : 32'(p + f - 1));
        chk("R8 intVectors", 32'(intVectors), 32'(p + f));
        chk("R8 activeFlexQ", 32'(activeFlexQ), 32'(f));
        chk("R8 activeFlexI", 32'(activeFlexI), 32'(p));
      end
    priPrivQ = 8'd200; pendFlexQ = 8'd100;
    pulse_reset(1'b1);
    chk("R8 wide sum", 32'(ioQueuePairs), 32'd299);

    // Controller reset leaves capacity alone: R9
    priPrivQ = 8'd5; pendFlexQ = 8'd9; priPrivI = 8'd1; pendFlexI = 8'd7;
    pulse_reset(1'b0);
    chk("R9 ioQueuePairs", 32'(ioQueuePairs), 32'd299);
    chk("R9 intVectors", 32'(intVectors), 32'd6);
    chk("R9 activeFlexQ", 32'(activeFlexQ), 32'd100);
    chk("R9 activeFlexI", 32'(activeFlexI), 32'd3);
    isVf = 1'b1; vfQueues = 8'd1;
    pulse_reset(1'b0);
    chk("R9 vf ioQueuePairs", 32'(ioQueuePairs), 32'd299);

    // Configuration monitor: R10 R11
    cfg_write(12'h168, 4'b0001, 32'h0000_0000, 16'd5, 1'b1);
    cfg_write(12'h168, 4'b0011, 32'h0000_0001, 16'd5, 1'b0);
    cfg_write(12'h168, 4'b1110, 32'h0000_0000, 16'd5, 1'b0);
    cfg_write(12'h16C, 4'b1111, 32'h0000_0000, 16'd5, 1'b0);
    cfg_write(12'h16A, 4'b1111, 32'hFFFF_FFFE, 16'd3, 1'b1);
    @(negedge clk);
    chk("R11 apply single cycle", 32'(cfgApply), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule